// File: doc/BRIEF.md
# Linear-cost share refresh for Boolean masking

This block re-randomizes a value held as N Boolean shares of W bits each. The value the shares encode (their XOR) does not change. One refresh takes the N input shares together with N-1 fresh random words. Each of the first N-1 shares is masked with its own random word. The last share absorbs every random word through a serial chain of XOR stages, in ascending word order starting with word 0. Each partial sum in that chain therefore depends on only one input share, and the cost grows linearly with N.

A producer presents shares and randoms with `in_valid_i`. The block is always ready, so every cycle with `in_valid_i` high is a refresh. The refreshed shares are registered, and `out_valid_o` marks them in the following cycle. Between refreshes the output registers keep their last contents. The randomness has to come from outside the block.

Top module: `mref_gadget`

## Requirements
- R1: Share i sits in bits [i*W +: W] of `shares_i` and of `shares_o`, and random word j sits in bits [j*W +: W] of `rand_i`. For every i from 0 to N-2, output share i equals input share i XOR random word i.
- R2: Output share N-1 equals input share N-1 XOR every random word 0..N-2. It is built as a chain of N-1 separate XOR stages, in ascending word order.
- R3: The XOR of all output shares equals the XOR of the input shares of the same refresh.
- R4: With all random words zero, every output share equals its input share.
- R5: `out_valid_o` is high exactly in the cycle after a cycle with `in_valid_i` high, and low otherwise.
- R6: In a cycle with `in_valid_i` low, `shares_o` keeps its previous contents.
- R7: While `rst_ni` is low, `out_valid_o` is low and `shares_o` is all zeros.
- R8: `in_ready_o` is always high, so every cycle with valid input is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input shares and randoms are valid |
| in_ready_o | output | 1 | Block accepts input (always high) |
| shares_i | input | N*W | Input shares, share i at [i*W +: W] |
| rand_i | input | (N-1)*W | Fresh random words, word j at [j*W +: W] |
| shares_o | output | N*W | Refreshed shares |
| out_valid_o | output | 1 | Refreshed shares valid |

## Verification
Every refresh result appears exactly one clock edge after the edge that accepts it. The bench drives inputs at the falling edge. At the accepting rising edge it queues the expected shares, computed from the masking equations. The monitor samples at the next falling edge, so it sees each result in its single due cycle. There it checks each lane, the last share and the XOR invariant. In idle cycles it checks that the outputs hold and that no valid appears without a queued refresh.

// File: rtl/mref_pkg.sv
package mref_pkg;
  localparam int unsigned MREF_MIN_SHARES = 2;

  function automatic int unsigned lane_lsb(input int unsigned idx, input int unsigned w);
    return idx * w;
  endfunction
endpackage

// File: rtl/mref_acc_stage.sv
// One XOR stage of the last-share accumulation chain.
module mref_acc_stage #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] rand_i,
  output logic [W-1:0] acc_o
);
  assign acc_o = acc_i ^ rand_i;
endmodule

// File: rtl/mref_lane_mask.sv
// Masks one of the first N-1 shares with its own random word.
module mref_lane_mask #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] share_i,
  input  logic [W-1:0] rand_i,
  output logic [W-1:0] share_o
);
  assign share_o = share_i ^ rand_i;
endmodule

// File: rtl/mref_out_reg.sv
module mref_out_reg #(
  parameter int unsigned SW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [SW-1:0] d_i,
  output logic [SW-1:0] q_o,
  output logic          vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o   <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= load_i;
      if (load_i) q_o <= d_i;
    end
  end
endmodule

// File: rtl/mref_gadget.sv
module mref_gadget
  import mref_pkg::*;
#(
  parameter int unsigned N = 4,
  parameter int unsigned W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [N*W-1:0]   shares_i,
  input  logic [(N-1)*W-1:0] rand_i,
  output logic [N*W-1:0]   shares_o,
  output logic             out_valid_o
);
  localparam int unsigned SW   = N * W;
  localparam int unsigned LAST = N - 1;

  if (N < MREF_MIN_SHARES) begin : g_bad_n
    initial $error("mref_gadget: N must be at least 2");
  end

  logic [W-1:0]  acc [N];
  logic [SW-1:0] nxt;

  assign in_ready_o = 1'b1;
  assign acc[0] = shares_i[lane_lsb(LAST, W) +: W];

  // serial chain: acc[j+1] = acc[j] ^ r_j, word 0 first
  for (genvar j = 0; j < N - 1; j++) begin : g_chain
    mref_acc_stage #(.W(W)) i_stage (
      .acc_i  (acc[j]),
      .rand_i (rand_i[j*W +: W]),
      .acc_o  (acc[j+1])
    );
  end

  for (genvar i = 0; i < N - 1; i++) begin : g_lane
    mref_lane_mask #(.W(W)) i_mask (
      .share_i (shares_i[i*W +: W]),
      .rand_i  (rand_i[i*W +: W]),
      .share_o (nxt[i*W +: W])
    );
  end

  assign nxt[LAST*W +: W] = acc[LAST];

  mref_out_reg #(.SW(SW)) i_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (in_valid_i & in_ready_o),
    .d_i    (nxt),
    .q_o    (shares_o),
    .vld_o  (out_valid_o)
  );
endmodule

// File: rtl/mref_gadget_chk.sv
module mref_gadget_chk #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               in_valid_i,
  input logic               in_ready_o,
  input logic [N*W-1:0]     shares_i,
  input logic [(N-1)*W-1:0] rand_i,
  input logic [N*W-1:0]     shares_o,
  input logic               out_valid_o
);
  function automatic logic [W-1:0] fold_shares(input logic [N*W-1:0] v);
    logic [W-1:0] f = '0;
    for (int k = 0; k < N; k++) f ^= v[k*W +: W];
    return f;
  endfunction

  function automatic logic [W-1:0] fold_rand(input logic [(N-1)*W-1:0] v);
    logic [W-1:0] f = '0;
    for (int k = 0; k < N - 1; k++) f ^= v[k*W +: W];
    return f;
  endfunction

  AST_LANE0_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> shares_o[W-1:0] == $past(shares_i[W-1:0] ^ rand_i[W-1:0])); // R1
  AST_LAST_ACCUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> shares_o[(N-1)*W +: W] ==
      ($past(shares_i[(N-1)*W +: W]) ^ $past(fold_rand(rand_i)))); // R2
  AST_VALUE_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> fold_shares(shares_o) == $past(fold_shares(shares_i))); // R3
  AST_ZERO_IDENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && rand_i == '0) |=> shares_o == $past(shares_i)); // R4
  AST_VALID_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o); // R5
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(shares_o)); // R6
  AST_READY_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o); // R8

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_IDLE: assert (!out_valid_o && shares_o == '0); // R7
    end
  end
endmodule

bind mref_gadget mref_gadget_chk #(.N(N), .W(W)) i_chk (.*);

// File: tb/test_mref_gadget.sv
module test_mref_gadget;
  localparam int unsigned N  = 4;
  localparam int unsigned W  = 8;
  localparam int unsigned SW = N * W;
  localparam int unsigned RW = (N - 1) * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [SW-1:0] shares_in = '0;
  logic [RW-1:0] rand_in = '0;
  logic [SW-1:0] shares_out;
  logic          out_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [SW-1:0] exp_q [$];
  logic [SW-1:0] src_q [$];
  bit            zero_q [$];
  logic [SW-1:0] last_exp = '0;

  always #4 clk = ~clk;

  mref_gadget #(.N(N), .W(W)) i_mref_gadget (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .shares_i    (shares_in),
    .rand_i      (rand_in),
    .shares_o    (shares_out),
    .out_valid_o (out_valid)
  );

  function automatic logic [W-1:0] fold(input logic [SW-1:0] v);
    logic [W-1:0] f = '0;
    for (int k = 0; k < N; k++) f ^= v[k*W +: W];
    return f;
  endfunction

  task automatic check(input bit ok, input string req, input logic [SW-1:0] act,
                       input logic [SW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [SW-1:0] x, input logic [RW-1:0] r, input bit v);
    logic [SW-1:0] e;
    logic [W-1:0]  last;
    @(negedge clk);
    shares_in = x;
    rand_in   = r;
    in_valid  = v;
    last = x[(N-1)*W +: W];
    for (int j = 0; j < N - 1; j++) begin
      e[j*W +: W] = x[j*W +: W] ^ r[j*W +: W];
      last ^= r[j*W +: W];
    end
    e[(N-1)*W +: W] = last;
    @(posedge clk);
    if (v) begin
      exp_q.push_back(e);
      src_q.push_back(x);
      zero_q.push_back(r == '0);
    end
  endtask

  // monitor: results due one edge after acceptance, sampled at falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 valid without refresh", shares_out, '0);
        end else begin
          logic [SW-1:0] e, x;
          bit z;
          e = exp_q.pop_front();
          x = src_q.pop_front();
          z = zero_q.pop_front();
          check(shares_out[(N-1)*W-1:0] == e[(N-1)*W-1:0], "R1 masked lanes",
                shares_out, e);
          check(shares_out[(N-1)*W +: W] == e[(N-1)*W +: W], "R2 last share",
                shares_out, e);
          check(fold(shares_out) == fold(x), "R3 xor preserved",
                {{(SW-W){1'b0}}, fold(shares_out)}, {{(SW-W){1'b0}}, fold(x)});
          if (z) check(shares_out == x, "R4 zero randoms identity", shares_out, x);
          last_exp = e;
        end
      end else begin
        check(exp_q.size() == 0, "R5 valid missing", shares_out, last_exp);
        check(shares_out == last_exp, "R6 hold when idle", shares_out, last_exp);
      end
      check(in_ready == 1'b1, "R8 ready", {{(SW-1){1'b0}}, in_ready}, 1);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(out_valid == 1'b0 && shares_out == '0, "R7 reset state", shares_out, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // R4: identity with zero randoms
    drive(32'h01234567, '0, 1'b1);
    drive(32'hFFFFFFFF, '0, 1'b1);
    drive(32'h00000000, '0, 1'b1);
    // R1 R2: single random word at a time
    for (int j = 0; j < N - 1; j++) begin
      logic [RW-1:0] r = '0;
      r[j*W +: W] = 8'hA5;
      drive(32'h11223344, r, 1'b1);
    end
    // R6: idle cycles
    drive(32'hDEADBEEF, 24'h123456, 1'b0);
    drive(32'hCAFEF00D, 24'h654321, 1'b0);
    // all-ones randoms
    drive(32'h0F0F0F0F, 24'hFFFFFF, 1'b1);
    // random stimulus with random gaps
    for (int n = 0; n < 300; n++) begin
      drive($urandom, RW'($urandom), ($urandom % 4) != 0);
    end
    drive('0, '0, 1'b0);
    drive('0, '0, 1'b0);
    @(negedge clk);
    check(exp_q.size() == 0, "R5 all results delivered", '0, '0);
    // R7: reset mid-run clears outputs
    rst_n = 1'b0;
    #2;
    check(out_valid == 1'b0 && shares_out == '0, "R7 reset clears", shares_out, '0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule